// File: doc/BRIEF.md
# Counter-Overflow Interrupt Enable Unit

This block decides which counter overflows are allowed to interrupt the processor. It watches one cycle counter and a parameterised number of event counters (three by default). It keeps two independent banks of per-counter enables. One bank drives a normal interrupt request and the other drives a fast interrupt request. Both requests are active low and registered. Each request is driven low while any counter has its overflow flag raised and its enable set in that bank.

Software reaches the banks through a small register port with four addresses. Address 0 sets IRQ enables and address 1 clears them. Address 2 sets FIQ enables and address 3 clears them. Address bit 1 therefore selects the bank and address bit 0 selects clear over set. Privileged accesses always succeed. A user-mode access succeeds only when the user-enable input is high. A refused access leaves the state alone, reads back zero and raises a one-cycle error pulse.

Top module: `cntovf_intr_gate`

## Requirements
- R1: In the 32-bit enable word, bit 31 is the cycle-counter enable and bit k (k = 0, 1, 2) is the enable for event counter k. Bits 30 to 3 always read zero, and any value written to them is dropped.
- R2: A read of a bank's set address or its clear address returns that bank's current enable word. The IRQ bank is at addresses 0 and 1, and the FIQ bank is at addresses 2 and 3.
- R3: A granted write to a set address (0 or 2) ORs the written ones into that bank. Zero bits leave the enables unchanged.
- R4: A granted write to a clear address (1 or 3) clears each enable whose written bit is one. Zero bits leave the enables unchanged.
- R5: `irq_req_n` is low exactly when, in the previous cycle, at least one counter had both its IRQ enable and its overflow flag set. It updates one clock after the enable or flag change that causes it.
- R6: `fiq_req_n` follows the same rule using the FIQ bank only. A write to one bank never alters the other bank.
- R7: With `priv_mode` = 1, every access is granted. With `priv_mode` = 0, an access is granted only when `user_en` = 1.
- R8: A refused access (user mode with `user_en` = 0) changes no enable and reads back zero. It also makes `acc_err` high for exactly the following cycle. A granted access leaves `acc_err` low.
- R9: Overflow flags are levels. A request stays low for as long as the flag and the enable stay set. It returns high one clock after either is cleared.
- R10: A synchronous active-high `rst` clears both banks and drives both request outputs high and `acc_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select (bit 1 = bank, bit 0 = clear) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (used to flag refused reads) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| priv_mode | input | 1 | 1 = privileged access |
| user_en | input | 1 | 1 = user-mode access permitted |
| evt_ovf | input | 3 | Sticky overflow flags of the event counters |
| cyc_ovf | input | 1 | Sticky overflow flag of the cycle counter |
| irq_req_n | output | 1 | Active-low normal interrupt request |
| fiq_req_n | output | 1 | Active-low fast interrupt request |
| acc_err | output | 1 | One-cycle pulse after a refused access |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high together. They also assume that the overflow flags and the port inputs change only away from the clock edge, so every request and error check can be tied to the single preceding cycle. The bench keeps to this by driving every input on the falling edge and raising one strobe per access. It holds the overflow flags as steady levels across several cycles, so the sticky-flag behaviour is checked under held inputs rather than glitches.

// File: rtl/cntovf_pkg.sv
package cntovf_pkg;

  // Register select: bit 1 picks the bank, bit 0 picks clear over set.
  typedef enum logic [1:0] {
    SEL_IRQ_SET = 2'd0,
    SEL_IRQ_CLR = 2'd1,
    SEL_FIQ_SET = 2'd2,
    SEL_FIQ_CLR = 2'd3
  } reg_sel_e;

  typedef enum logic {
    BANK_IRQ = 1'b0,
    BANK_FIQ = 1'b1
  } bank_e;

  typedef struct packed {
    logic set;
    logic clr;
  } bank_cmd_t;

endpackage

// File: rtl/cntovf_acc_gate.sv
module cntovf_acc_gate
  import cntovf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [1:0]            reg_addr,
  input  logic                  priv_mode,
  input  logic                  user_en,
  output logic                  grant,
  output bank_cmd_t [1:0]       cmd,
  output logic                  deny_evt,
  output logic                  acc_err
);

  function automatic logic may_access(input logic priv, input logic uen);
    return priv | uen;
  endfunction

  assign grant    = may_access(priv_mode, user_en);
  assign deny_evt = (reg_wr | reg_rd) & ~grant;

  always_comb begin
    cmd = '0;
    if (reg_wr && grant) begin
      case (reg_sel_e'(reg_addr))
        SEL_IRQ_SET: cmd[BANK_IRQ].set = 1'b1;
        SEL_IRQ_CLR: cmd[BANK_IRQ].clr = 1'b1;
        SEL_FIQ_SET: cmd[BANK_FIQ].set = 1'b1;
        SEL_FIQ_CLR: cmd[BANK_FIQ].clr = 1'b1;
        default:     cmd = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_err <= 1'b0;
    else     acc_err <= deny_evt;
  end

endmodule

// File: rtl/cntovf_en_bank.sv
module cntovf_en_bank #(
  parameter int NEVT = 3,
  parameter int DW   = 32,
  parameter int CYCB = 31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_stb,
  input  logic          clr_stb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] word
);

  // Only implemented enable positions survive a write.
  function automatic logic [DW-1:0] keep_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int k = 0; k < NEVT; k++) m[k] = 1'b1;
    m[CYCB] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] KEEP = keep_mask();

  function automatic logic [DW-1:0] apply_set(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] d);
    return cur | (d & KEEP);
  endfunction

  function automatic logic [DW-1:0] apply_clr(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] d);
    return cur & ~(d & KEEP);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)          word <= '0;
    else if (set_stb) word <= apply_set(word, wdata);
    else if (clr_stb) word <= apply_clr(word, wdata);
  end

endmodule

// File: rtl/cntovf_req_stage.sv
module cntovf_req_stage #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] en,
  input  logic [NB-1:0] ovf,
  output logic          req_n
);

  function automatic logic any_hit(input logic [NB-1:0] e,
                                   input logic [NB-1:0] f);
    return |(e & f);
  endfunction

  logic hit;
  assign hit = any_hit(en, ovf);

  always_ff @(posedge clk) begin
    if (rst) req_n <= 1'b1;
    else     req_n <= ~hit;
  end

endmodule

// File: rtl/cntovf_intr_gate.sv
module cntovf_intr_gate
  import cntovf_pkg::*;
#(
  parameter int NEVT = 3,
  parameter int DW   = 32,
  parameter int CYCB = 31
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            priv_mode,
  input  logic            user_en,
  input  logic [NEVT-1:0] evt_ovf,
  input  logic            cyc_ovf,
  output logic            irq_req_n,
  output logic            fiq_req_n,
  output logic            acc_err
);

  localparam int NB     = NEVT + 1;
  localparam int NBANKS = 2;

  // Compact enable vector: event counters low, cycle counter on top.
  function automatic logic [NB-1:0] compact(input logic [DW-1:0] w);
    logic [NB-1:0] r;
    for (int k = 0; k < NEVT; k++) r[k] = w[k];
    r[NEVT] = w[CYCB];
    return r;
  endfunction

  logic                  grant;
  logic                  deny_evt;
  logic                  wr_grant;
  bank_cmd_t [1:0]       cmd;
  logic [DW-1:0]         bank_word [NBANKS];
  logic [NB-1:0]         bank_en   [NBANKS];
  logic [NBANKS-1:0]     req_n;
  logic [NB-1:0]         ovf_vec;
  logic [NB-1:0]         irq_en;
  logic [NB-1:0]         fiq_en;

  assign ovf_vec  = {cyc_ovf, evt_ovf};
  assign wr_grant = reg_wr & grant;

  cntovf_acc_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .priv_mode (priv_mode),
    .user_en   (user_en),
    .grant     (grant),
    .cmd       (cmd),
    .deny_evt  (deny_evt),
    .acc_err   (acc_err)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    cntovf_en_bank #(
      .NEVT (NEVT),
      .DW   (DW),
      .CYCB (CYCB)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .set_stb (cmd[b].set),
      .clr_stb (cmd[b].clr),
      .wdata   (reg_wdata),
      .word    (bank_word[b])
    );

    assign bank_en[b] = compact(bank_word[b]);

    cntovf_req_stage #(
      .NB (NB)
    ) u_req (
      .clk   (clk),
      .rst   (rst),
      .en    (bank_en[b]),
      .ovf   (ovf_vec),
      .req_n (req_n[b])
    );
  end

  assign irq_en    = bank_en[BANK_IRQ];
  assign fiq_en    = bank_en[BANK_FIQ];
  assign irq_req_n = req_n[BANK_IRQ];
  assign fiq_req_n = req_n[BANK_FIQ];
  assign reg_rdata = grant ? bank_word[reg_addr[1]] : '0;

endmodule

// File: rtl/cntovf_chk.sv
module cntovf_chk #(
  parameter int NEVT = 3,
  parameter int DW   = 32,
  parameter int CYCB = 31,
  parameter int NB   = NEVT + 1
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    reg_addr,
  input logic          reg_wr,
  input logic          priv_mode,
  input logic          user_en,
  input logic [DW-1:0] reg_rdata,
  input logic          wr_grant,
  input logic          deny_evt,
  input logic [NB-1:0] irq_en,
  input logic [NB-1:0] fiq_en,
  input logic [NB-1:0] ovf_vec,
  input logic          irq_req_n,
  input logic          fiq_req_n,
  input logic          acc_err
);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[CYCB-1:NEVT] == '0);

  a_r3_set_only_adds: assert property (@(posedge clk) disable iff (rst)
    (wr_grant && reg_addr == 2'd0) |=> ((irq_en & $past(irq_en)) == $past(irq_en)));

  a_r4_clear_only_removes: assert property (@(posedge clk) disable iff (rst)
    (wr_grant && reg_addr == 2'd1) |=> ((irq_en | $past(irq_en)) == $past(irq_en)));

  a_r5_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_req_n == !(|$past(irq_en & ovf_vec))));

  a_r6_fiq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fiq_req_n == !(|$past(fiq_en & ovf_vec))));

  a_r6_irq_write_spares_fiq: assert property (@(posedge clk) disable iff (rst)
    (wr_grant && !reg_addr[1]) |=> $stable(fiq_en));

  a_r8_denied_no_change: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !priv_mode && !user_en) |=> ($stable(irq_en) && $stable(fiq_en)));

  a_r8_denied_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (!priv_mode && !user_en) |-> (reg_rdata == '0));

  a_r8_err_pulse: assert property (@(posedge clk) disable iff (rst)
    deny_evt |=> acc_err);

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
    !deny_evt |=> !acc_err);

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (irq_en == '0 && fiq_en == '0 && irq_req_n && fiq_req_n && !acc_err));

endmodule

bind cntovf_intr_gate cntovf_chk #(
  .NEVT (NEVT),
  .DW   (DW),
  .CYCB (CYCB),
  .NB   (NB)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .priv_mode (priv_mode),
  .user_en   (user_en),
  .reg_rdata (reg_rdata),
  .wr_grant  (wr_grant),
  .deny_evt  (deny_evt),
  .irq_en    (irq_en),
  .fiq_en    (fiq_en),
  .ovf_vec   (ovf_vec),
  .irq_req_n (irq_req_n),
  .fiq_req_n (fiq_req_n),
  .acc_err   (acc_err)
);

// File: tb/cntovf_intr_gate_bench.sv
`timescale 1ns/1ps
module cntovf_intr_gate_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        priv_mode = 1'b1;
  logic        user_en = 1'b0;
  logic [2:0]  evt_ovf = '0;
  logic        cyc_ovf = 1'b0;
  logic        irq_req_n;
  logic        fiq_req_n;
  logic        acc_err;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  cntovf_intr_gate u_cntovf_intr_gate (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .priv_mode (priv_mode),
    .user_en   (user_en),
    .evt_ovf   (evt_ovf),
    .cyc_ovf   (cyc_ovf),
    .irq_req_n (irq_req_n),
    .fiq_req_n (fiq_req_n),
    .acc_err   (acc_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at falling edge, commit at rising edge, release at next falling edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic p, input logic u);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; priv_mode = p; user_en = u; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; priv_mode = 1'b1; user_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic p, input logic u, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a; priv_mode = p; user_en = u; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0; priv_mode = 1'b1; user_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R10 irq_req_n after reset", {31'd0, irq_req_n}, 32'd1);
    chk("R10 fiq_req_n after reset", {31'd0, fiq_req_n}, 32'd1);
    chk("R10 acc_err after reset", {31'd0, acc_err}, 32'd0);
    rd(2'd0, 1'b1, 1'b0, v); chk("R10 irq bank clear", v, 32'd0);
    rd(2'd2, 1'b1, 1'b0, v); chk("R10 fiq bank clear", v, 32'd0);
  endtask

  task automatic t_layout();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFF, 1'b1, 1'b0);
    rd(2'd0, 1'b1, 1'b0, v); chk("R1 reserved bits dropped", v, 32'h8000_0007);
    wr(2'd1, 32'hFFFF_FFFF, 1'b1, 1'b0);
    rd(2'd0, 1'b1, 1'b0, v); chk("R1 all enables cleared", v, 32'd0);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(2'd2, 32'h0000_0005, 1'b1, 1'b0);
    rd(2'd2, 1'b1, 1'b0, v); chk("R2 fiq set alias", v, 32'h5);
    rd(2'd3, 1'b1, 1'b0, v); chk("R2 fiq clear alias", v, 32'h5);
    rd(2'd1, 1'b1, 1'b0, v); chk("R6 irq bank untouched", v, 32'h0);
    wr(2'd3, 32'hFFFF_FFFF, 1'b1, 1'b0);
  endtask

  task automatic t_setclr();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0001, 1'b1, 1'b0);
    wr(2'd0, 32'h8000_0000, 1'b1, 1'b0);
    rd(2'd0, 1'b1, 1'b0, v); chk("R3 set accumulates", v, 32'h8000_0001);
    wr(2'd0, 32'h0000_0000, 1'b1, 1'b0);
    rd(2'd0, 1'b1, 1'b0, v); chk("R3 zero set no effect", v, 32'h8000_0001);
    wr(2'd1, 32'h0000_0001, 1'b1, 1'b0);
    rd(2'd1, 1'b1, 1'b0, v); chk("R4 clear one bit", v, 32'h8000_0000);
    wr(2'd1, 32'h0000_0000, 1'b1, 1'b0);
    rd(2'd1, 1'b1, 1'b0, v); chk("R4 zero clear no effect", v, 32'h8000_0000);
    wr(2'd1, 32'hFFFF_FFFF, 1'b1, 1'b0);
  endtask

  task automatic t_irq();
    wr(2'd0, 32'h0000_0002, 1'b1, 1'b0);
    @(negedge clk);
    chk("R5 no flag no request", {31'd0, irq_req_n}, 32'd1);
    evt_ovf = 3'b010;
    #1 chk("R5 request is registered", {31'd0, irq_req_n}, 32'd1);
    @(negedge clk);
    chk("R5 irq low one cycle later", {31'd0, irq_req_n}, 32'd0);
    chk("R6 fiq unaffected", {31'd0, fiq_req_n}, 32'd1);
    evt_ovf = 3'b001;
    @(negedge clk);
    chk("R5 disabled counter no request", {31'd0, irq_req_n}, 32'd1);
    cyc_ovf = 1'b1;
    wr(2'd0, 32'h8000_0000, 1'b1, 1'b0);
    chk("R5 enable not yet visible", {31'd0, irq_req_n}, 32'd1);
    @(negedge clk);
    chk("R5 cycle-counter request", {31'd0, irq_req_n}, 32'd0);
  endtask

  task automatic t_hold();
    repeat (5) @(negedge clk);
    chk("R9 request held", {31'd0, irq_req_n}, 32'd0);
    cyc_ovf = 1'b0;
    @(negedge clk);
    chk("R9 release on flag clear", {31'd0, irq_req_n}, 32'd1);
    cyc_ovf = 1'b1;
    @(negedge clk);
    chk("R9 reassert on flag", {31'd0, irq_req_n}, 32'd0);
    wr(2'd1, 32'h8000_0000, 1'b1, 1'b0);
    chk("R9 still low right after clear write", {31'd0, irq_req_n}, 32'd0);
    @(negedge clk);
    chk("R9 release on enable clear", {31'd0, irq_req_n}, 32'd1);
    cyc_ovf = 1'b0; evt_ovf = '0;
    wr(2'd1, 32'hFFFF_FFFF, 1'b1, 1'b0);
  endtask

  task automatic t_user();
    logic [31:0] v;
    wr(2'd2, 32'h0000_0004, 1'b0, 1'b1);
    chk("R7 user write no error", {31'd0, acc_err}, 32'd0);
    rd(2'd2, 1'b0, 1'b1, v); chk("R7 user read granted", v, 32'h4);
    evt_ovf = 3'b100;
    @(negedge clk);
    @(negedge clk);
    chk("R6 fiq request from fiq bank", {31'd0, fiq_req_n}, 32'd0);
    chk("R6 irq stays high", {31'd0, irq_req_n}, 32'd1);
    evt_ovf = '0;
  endtask

  task automatic t_deny();
    logic [31:0] v;
    wr(2'd3, 32'h0000_0004, 1'b0, 1'b0);
    chk("R8 error pulse after denied write", {31'd0, acc_err}, 32'd1);
    @(negedge clk);
    chk("R8 error lasts one cycle", {31'd0, acc_err}, 32'd0);
    rd(2'd2, 1'b1, 1'b0, v); chk("R8 denied write no change", v, 32'h4);
    rd(2'd2, 1'b0, 1'b0, v); chk("R8 denied read zero", v, 32'h0);
    chk("R8 error after denied read", {31'd0, acc_err}, 32'd1);
    wr(2'd0, 32'h0000_0001, 1'b0, 1'b0);
    rd(2'd0, 1'b1, 1'b0, v); chk("R8 denied set no change", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_layout();
    t_alias();
    t_setclr();
    t_irq();
    t_hold();
    t_user();
    t_deny();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule